// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block performs host-requested reads from a one-time-programmable fuse array. A request gives a byte start address, a byte count and a flag that selects the reduced power sequence. The block checks that the request is word aligned. It then powers the fuse macro up in a fixed order that includes a settle delay. Next it fetches each 32-bit word through an address/ready handshake and sends the bytes out on a valid/ready stream. Finally it powers the macro down in reverse order and signals completion with a one-cycle done pulse carrying a status code.

The settle delay and the ready timeout are cycle counts derived from a clock-frequency parameter and microsecond parameters. A simulation switch replaces both with short counts. Status codes on `err_o` are 0 for success, 1 for a misaligned request and 2 for a ready timeout.

Top module: `fuse_rd_seq`

## Requirements
- R1: If the start address or the byte count is not a multiple of 4, the done pulse carries status 1. No power output changes, no fuse request is issued and no byte is emitted.
- R2: An aligned request with a byte count of zero completes with status 0. No power output changes and no fuse request is issued.
- R3: Power-up applies these steps on successive register updates: write-mask override on, first switch on, a wait, second switch on, isolation released (iso_o low), burst on. The second switch rises at least SETTLE_CYC cycles after the first. Isolation is never released unless both switches are on.
- R4: Power-down applies these steps: isolation on, second switch off, a wait, first switch off, write-mask override off, burst off. The first switch falls at least SETTLE_CYC cycles after the second.
- R5: When the reduced-sequence flag is set with a request, only the write-mask override and burst outputs toggle (override on, burst on, override off, burst off). Switches and isolation keep their reset levels.
- R6: For each word, fuse_req_o pulses for one cycle with fuse_addr_o equal to the word's byte address. The first address is the start address and each later one is 4 higher. Requests occur only while burst and write-mask override are on.
- R7: Each word is emitted as 4 bytes, least significant byte first. Exactly as many bytes as the byte count are emitted.
- R8: If fuse_rdy_i does not come high within TIMEOUT_CYC cycles of a request, the block stops reading and emits no bytes of that word. It runs the full power-down sequence and then reports status 2.
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o stays unchanged on the next cycle.
- R10: done_o is high for exactly one cycle per accepted request. req_ready_o is high only while the block is idle, and it is high after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Block idle, request accepted when valid |
| req_addr_i | input | AW | Byte start address |
| req_len_i | input | LW | Byte count |
| skip_pwr_i | input | 1 | Reduced power sequence for this request |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Output byte accepted |
| out_data_o | output | 8 | Output byte |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Status with done: 0 ok, 1 misaligned, 2 timeout |
| wm_ovr_o | output | 1 | Write-mask override enable |
| pwr_sw1_o | output | 1 | First power switch |
| pwr_sw2_o | output | 1 | Second power switch |
| iso_o | output | 1 | Core isolation, high isolates |
| burst_o | output | 1 | Burst read enable |
| fuse_req_o | output | 1 | Address write strobe, clears macro ready |
| fuse_addr_o | output | AW | Word byte address to macro |
| fuse_rdy_i | input | 1 | Macro data ready |
| fuse_data_i | input | 32 | Macro read data |

## Verification
A wrong sequencer state usually shows first on the power outputs. It appears as a step out of order, a settle gap shorter than the parameter, or a switch that toggles in reduced mode. The monitor catches it on the cycle of the faulty edge. A fault in the word path shows as a wrong fuse address on the next request pulse, or as a byte swap or missing byte at the stream output within four beats of the word. A fault in the timeout or error path shows at the done pulse as a wrong status code or as unexpected bytes.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_ALIGN = 2'd1,
    ERR_BUSY  = 2'd2
  } fuse_err_e;

  typedef enum logic [2:0] {
    T_IDLE, T_PWR_UP, T_ISSUE, T_WAIT, T_DRAIN, T_PWR_DN, T_DONE
  } top_st_e;

  typedef enum logic [3:0] {
    P_IDLE, P_WM_ON, P_SW1_ON, P_WAIT_UP, P_SW2_ON, P_ISO_OFF, P_BURST_ON,
    P_ISO_ON, P_SW2_OFF, P_WAIT_DN, P_SW1_OFF, P_WM_OFF, P_BURST_OFF
  } pwr_st_e;

  localparam int unsigned BYTES_PER_WORD = 4;
endpackage

// File: rtl/fuse_pwr_seq.sv
module fuse_pwr_seq
  import fuse_rd_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_i,
  input  logic dn_i,
  input  logic skip_i,
  output logic done_o,
  output logic wm_o,
  output logic sw1_o,
  output logic sw2_o,
  output logic iso_o,
  output logic burst_o
);
  localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);

  pwr_st_e       st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= P_IDLE;
      cnt_q   <= '0;
      wm_o    <= 1'b0;
      sw1_o   <= 1'b0;
      sw2_o   <= 1'b0;
      iso_o   <= 1'b1;
      burst_o <= 1'b0;
    end else begin
      unique case (st_q)
        P_IDLE: begin
          if (up_i)      st_q <= P_WM_ON;
          else if (dn_i) st_q <= skip_i ? P_WM_OFF : P_ISO_ON;
        end
        P_WM_ON: begin
          wm_o <= 1'b1;
          st_q <= skip_i ? P_BURST_ON : P_SW1_ON;
        end
        P_SW1_ON: begin
          sw1_o <= 1'b1;
          cnt_q <= '0;
          st_q  <= P_WAIT_UP;
        end
        P_WAIT_UP: begin
          if (cnt_q == CW'(SETTLE_CYC - 1)) st_q <= P_SW2_ON;
          else cnt_q <= cnt_q + 1'b1;
        end
        P_SW2_ON: begin
          sw2_o <= 1'b1;
          st_q  <= P_ISO_OFF;
        end
        P_ISO_OFF: begin
          iso_o <= 1'b0;
          st_q  <= P_BURST_ON;
        end
        P_BURST_ON: begin
          burst_o <= 1'b1;
          st_q    <= P_IDLE;
        end
        P_ISO_ON: begin
          iso_o <= 1'b1;
          st_q  <= P_SW2_OFF;
        end
        P_SW2_OFF: begin
          sw2_o <= 1'b0;
          cnt_q <= '0;
          st_q  <= P_WAIT_DN;
        end
        P_WAIT_DN: begin
          if (cnt_q == CW'(SETTLE_CYC - 1)) st_q <= P_SW1_OFF;
          else cnt_q <= cnt_q + 1'b1;
        end
        P_SW1_OFF: begin
          sw1_o <= 1'b0;
          st_q  <= P_WM_OFF;
        end
        P_WM_OFF: begin
          wm_o <= 1'b0;
          st_q <= P_BURST_OFF;
        end
        P_BURST_OFF: begin
          burst_o <= 1'b0;
          st_q    <= P_IDLE;
        end
        default: st_q <= P_IDLE;
      endcase
    end
  end

  // last step of either direction is being applied
  assign done_o = (st_q == P_BURST_ON) || (st_q == P_BURST_OFF);
endmodule

// File: rtl/fuse_word_rd.sv
module fuse_word_rd #(
  parameter int unsigned AW          = 16,
  parameter int unsigned DW          = 32,
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          fuse_req_o,
  output logic [AW-1:0] fuse_addr_o,
  input  logic          fuse_rdy_i,
  input  logic [DW-1:0] fuse_data_i,
  output logic [DW-1:0] word_o,
  output logic          word_vld_o,
  output logic          tmo_o
);
  localparam int unsigned TW = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC + 1);

  logic          wait_q, req_q, vld_q, tmo_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] word_q;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      req_q  <= 1'b0;
      vld_q  <= 1'b0;
      tmo_q  <= 1'b0;
      addr_q <= '0;
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      req_q <= 1'b0;
      vld_q <= 1'b0;
      tmo_q <= 1'b0;
      if (!wait_q) begin
        if (start_i) begin
          wait_q <= 1'b1;
          req_q  <= 1'b1;
          addr_q <= addr_i;
          cnt_q  <= '0;
        end
      end else if (fuse_rdy_i && !req_q) begin
        // ready seen during the strobe cycle is stale from the previous word
        word_q <= fuse_data_i;
        vld_q  <= 1'b1;
        wait_q <= 1'b0;
      end else if (cnt_q == TW'(TIMEOUT_CYC - 1)) begin
        tmo_q  <= 1'b1;
        wait_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fuse_req_o  = req_q;
  assign fuse_addr_o = addr_q;
  assign word_o      = word_q;
  assign word_vld_o  = vld_q;
  assign tmo_o       = tmo_q;
endmodule

// File: rtl/fuse_byte_ser.sv
module fuse_byte_ser #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] word_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [7:0]    out_data_o,
  output logic          empty_o
);
  localparam int unsigned NB = DW / 8;
  localparam int unsigned BW = $clog2(NB + 1);

  logic [DW-1:0] sh_q;
  logic [BW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= word_i;
      left_q <= BW'(NB);
    end else if (left_q != '0 && out_ready_i) begin
      sh_q   <= sh_q >> 8;
      left_q <= left_q - 1'b1;
    end
  end

  assign out_valid_o = (left_q != '0);
  assign out_data_o  = sh_q[7:0];
  assign empty_o     = (left_q == '0);
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int unsigned AW           = 16,
  parameter int unsigned LW           = 16,
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned SETTLE_US    = 1000,
  parameter int unsigned TIMEOUT_US   = 1000000,
  parameter bit          SIM_FAST     = 1'b0,
  parameter int unsigned FAST_SETTLE  = 16,
  parameter int unsigned FAST_TIMEOUT = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [LW-1:0] req_len_i,
  input  logic          skip_pwr_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [7:0]    out_data_o,
  output logic          done_o,
  output logic [1:0]    err_o,
  output logic          wm_ovr_o,
  output logic          pwr_sw1_o,
  output logic          pwr_sw2_o,
  output logic          iso_o,
  output logic          burst_o,
  output logic          fuse_req_o,
  output logic [AW-1:0] fuse_addr_o,
  input  logic          fuse_rdy_i,
  input  logic [31:0]   fuse_data_i
);
  localparam int unsigned DW          = 8 * BYTES_PER_WORD;
  localparam int unsigned SETTLE_CYC  = SIM_FAST ? FAST_SETTLE  : CLK_MHZ * SETTLE_US;
  localparam int unsigned TIMEOUT_CYC = SIM_FAST ? FAST_TIMEOUT : CLK_MHZ * TIMEOUT_US;
  localparam int unsigned NW          = LW - 2;

  top_st_e       st_q;
  fuse_err_e     err_q;
  logic [AW-1:0] addr_q;
  logic [NW-1:0] left_q;
  logic          skip_q;

  logic          misalign, zero_len, up_go, dn_go, rd_start, ser_load;
  logic          pwr_done, word_vld, tmo, ser_empty, pwr_skip;
  logic [DW-1:0] word;

  assign misalign = (|req_addr_i[1:0]) || (|req_len_i[1:0]);
  assign zero_len = (req_len_i == '0);
  assign up_go    = (st_q == T_IDLE) && req_valid_i && !misalign && !zero_len;
  assign rd_start = (st_q == T_ISSUE);
  assign ser_load = (st_q == T_WAIT) && word_vld;
  assign dn_go    = ((st_q == T_WAIT) && !word_vld && tmo) ||
                    ((st_q == T_DRAIN) && ser_empty && left_q == '0);
  assign pwr_skip = (st_q == T_IDLE) ? skip_pwr_i : skip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= T_IDLE;
      err_q  <= ERR_NONE;
      addr_q <= '0;
      left_q <= '0;
      skip_q <= 1'b0;
    end else begin
      unique case (st_q)
        T_IDLE: if (req_valid_i) begin
          skip_q <= skip_pwr_i;
          addr_q <= req_addr_i;
          left_q <= req_len_i[LW-1:2];
          if (misalign) begin
            err_q <= ERR_ALIGN;
            st_q  <= T_DONE;
          end else begin
            err_q <= ERR_NONE;
            st_q  <= zero_len ? T_DONE : T_PWR_UP;
          end
        end
        T_PWR_UP: if (pwr_done) st_q <= T_ISSUE;
        T_ISSUE:  st_q <= T_WAIT;
        T_WAIT: begin
          if (word_vld) begin
            addr_q <= addr_q + AW'(BYTES_PER_WORD);
            left_q <= left_q - 1'b1;
            st_q   <= T_DRAIN;
          end else if (tmo) begin
            err_q <= ERR_BUSY;
            st_q  <= T_PWR_DN;
          end
        end
        T_DRAIN: if (ser_empty) st_q <= (left_q == '0) ? T_PWR_DN : T_ISSUE;
        T_PWR_DN: if (pwr_done) st_q <= T_DONE;
        T_DONE:   st_q <= T_IDLE;
        default:  st_q <= T_IDLE;
      endcase
    end
  end

  fuse_pwr_seq #(.SETTLE_CYC(SETTLE_CYC)) u_pwr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .up_i    (up_go),
    .dn_i    (dn_go),
    .skip_i  (pwr_skip),
    .done_o  (pwr_done),
    .wm_o    (wm_ovr_o),
    .sw1_o   (pwr_sw1_o),
    .sw2_o   (pwr_sw2_o),
    .iso_o   (iso_o),
    .burst_o (burst_o)
  );

  fuse_word_rd #(.AW(AW), .DW(DW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_word (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (rd_start),
    .addr_i      (addr_q),
    .fuse_req_o  (fuse_req_o),
    .fuse_addr_o (fuse_addr_o),
    .fuse_rdy_i  (fuse_rdy_i),
    .fuse_data_i (fuse_data_i),
    .word_o      (word),
    .word_vld_o  (word_vld),
    .tmo_o       (tmo)
  );

  fuse_byte_ser #(.DW(DW)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ser_load),
    .word_i      (word),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .empty_o     (ser_empty)
  );

  assign req_ready_o = (st_q == T_IDLE);
  assign done_o      = (st_q == T_DONE);
  assign err_o       = done_o ? err_q : ERR_NONE;
endmodule

// File: rtl/fuse_rd_seq_chk.sv
module fuse_rd_seq_chk #(
  parameter int unsigned SETTLE_CYC = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input logic       done_o,
  input logic       wm_ovr_o,
  input logic       pwr_sw1_o,
  input logic       pwr_sw2_o,
  input logic       iso_o,
  input logic       burst_o,
  input logic       fuse_req_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 2);

  logic [CW-1:0] up_cnt, dn_cnt;

  // saturating cycle counts of the two settle windows
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_cnt <= '0;
      dn_cnt <= '0;
    end else begin
      if (!pwr_sw1_o) up_cnt <= '0;
      else if (up_cnt != CW'(SETTLE_CYC)) up_cnt <= up_cnt + 1'b1;
      if (pwr_sw2_o || !pwr_sw1_o) dn_cnt <= '0;
      else if (dn_cnt != CW'(SETTLE_CYC)) dn_cnt <= dn_cnt + 1'b1;
    end
  end

  a_r3_iso_needs_switches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iso_o |-> (pwr_sw1_o && pwr_sw2_o));
  a_r3_settle_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_sw2_o) |-> (up_cnt == CW'(SETTLE_CYC)));
  a_r4_settle_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_sw1_o) |-> (dn_cnt == CW'(SETTLE_CYC)));
  a_r6_req_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_req_o |-> (burst_o && wm_ovr_o));
  a_r9_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!out_valid_o && !fuse_req_o && !done_o));
endmodule

bind fuse_rd_seq fuse_rd_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .done_o      (done_o),
  .wm_ovr_o    (wm_ovr_o),
  .pwr_sw1_o   (pwr_sw1_o),
  .pwr_sw2_o   (pwr_sw2_o),
  .iso_o       (iso_o),
  .burst_o     (burst_o),
  .fuse_req_o  (fuse_req_o)
);

// File: tb/fuse_macro_model.sv
module fuse_macro_model (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  lat_i,
  input  logic        hang_i,
  output logic        rdy_o,
  output logic [31:0] data_o
);
  logic [15:0] a_q;
  logic [7:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_o  <= 1'b0;
      data_o <= '0;
      a_q    <= '0;
      cnt_q  <= '0;
    end else if (req_i) begin
      rdy_o <= 1'b0;
      a_q   <= addr_i;
      cnt_q <= lat_i;
    end else if (!rdy_o && !hang_i) begin
      if (cnt_q == 8'd0) begin
        rdy_o  <= 1'b1;
        data_o <= {a_q[7:0] ^ 8'h3C, a_q[15:8] ^ 8'h81, ~a_q[7:0], a_q[7:0] ^ 8'hC5};
      end else begin
        cnt_q <= cnt_q - 8'd1;
      end
    end
  end
endmodule

// File: tb/fuse_rd_seq_tb.sv
module fuse_rd_seq_tb;
  localparam int SETTLE = 16;
  localparam int TMO    = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, skip = 1'b0;
  logic [15:0] req_addr = '0, req_len = '0;
  logic        out_valid, out_ready = 1'b1, done;
  logic [7:0]  out_data;
  logic [1:0]  err;
  logic        wm, sw1, sw2, iso, burst, freq, frdy, hang = 1'b0;
  logic [15:0] faddr;
  logic [31:0] fdata;
  logic [7:0]  lat = 8'd3;
  bit          bp_en = 1'b0;

  always #5 clk = ~clk;

  fuse_rd_seq #(.SIM_FAST(1'b1), .FAST_SETTLE(SETTLE), .FAST_TIMEOUT(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .skip_pwr_i(skip),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .done_o(done), .err_o(err), .wm_ovr_o(wm), .pwr_sw1_o(sw1), .pwr_sw2_o(sw2),
    .iso_o(iso), .burst_o(burst), .fuse_req_o(freq), .fuse_addr_o(faddr),
    .fuse_rdy_i(frdy), .fuse_data_i(fdata)
  );

  fuse_macro_model u_fuse (
    .clk_i(clk), .rst_ni(rst_n), .req_i(freq), .addr_i(faddr), .lat_i(lat),
    .hang_i(hang), .rdy_o(frdy), .data_o(fdata)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [15:0] a, input int k);
    case (k)
      0:       return a[7:0] ^ 8'hC5;
      1:       return ~a[7:0];
      2:       return a[15:8] ^ 8'h81;
      default: return a[7:0] ^ 8'h3C;
    endcase
  endfunction

  // monitor
  int          cyc = 0;
  int          ev[64];
  int          n_ev = 0;
  logic [7:0]  bytes_q[256];
  int          n_byte = 0;
  int          req_a[64];
  int          n_req = 0;
  bit          done_seen = 0;
  logic [1:0]  done_err = '0;
  int          done_cnt = 0, stall_bad = 0, rr_bad = 0;
  int          sw1_up = 0, sw2_up = 0, sw2_dn = 0, sw1_dn = 0;
  bit          busy = 0;
  logic        p_wm = 0, p_sw1 = 0, p_sw2 = 0, p_iso = 1, p_burst = 0;
  logic        p_vld = 0, p_rdy = 0;
  logic [7:0]  p_data = '0;

  task automatic log_ev(input int code);
    if (n_ev < 64) ev[n_ev] = code;
    n_ev++;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (wm != p_wm)       log_ev(wm ? 1 : 9);
      if (sw1 != p_sw1)     begin log_ev(sw1 ? 2 : 8); if (sw1) sw1_up = cyc; else sw1_dn = cyc; end
      if (sw2 != p_sw2)     begin log_ev(sw2 ? 3 : 7); if (sw2) sw2_up = cyc; else sw2_dn = cyc; end
      if (iso != p_iso)     log_ev(iso ? 6 : 4);
      if (burst != p_burst) log_ev(burst ? 5 : 10);
      if (freq) begin
        if (n_req < 64) req_a[n_req] = int'(faddr);
        n_req++;
      end
      if (out_valid && out_ready) begin
        if (n_byte < 256) bytes_q[n_byte] = out_data;
        n_byte++;
      end
      if (p_vld && !p_rdy && !(out_valid && out_data == p_data)) stall_bad++;
      if (busy && req_ready) rr_bad++;
      if (req_valid && req_ready) busy = 1;
      if (done) begin
        done_seen = 1;
        done_err  = err;
        done_cnt++;
        busy = 0;
      end
    end
    p_wm = wm; p_sw1 = sw1; p_sw2 = sw2; p_iso = iso; p_burst = burst;
    p_vld = out_valid; p_rdy = out_ready; p_data = out_data;
  end

  always @(negedge clk) out_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;

  task automatic clear_log();
    n_ev = 0; n_byte = 0; n_req = 0; done_seen = 0; done_cnt = 0;
    stall_bad = 0; rr_bad = 0;
  endtask

  task automatic run_req(input int a, input int l, input bit sk);
    @(negedge clk);
    clear_log();
    req_addr  = 16'(a);
    req_len   = 16'(l);
    skip      = sk;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 5000 && !done_seen; i++) @(negedge clk);
    chk(done_seen, "R10 done never seen", 0, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_bytes(input string tag, input int a, input int l);
    chk(n_byte == l, {tag, " byte count"}, n_byte, l);
    for (int i = 0; i < l && i < 256; i++) begin
      logic [7:0] e;
      e = exp_byte(16'(a + 4 * (i / 4)), i % 4);
      if (bytes_q[i] !== e) begin
        chk(0, {tag, " byte value"}, int'(bytes_q[i]), int'(e));
        break;
      end
    end
    chk(1, {tag, " bytes scanned"}, 0, 0);
  endtask

  task automatic chk_full_seq(input string tag);
    int bad;
    bad = (n_ev != 10) ? 1 : 0;
    for (int i = 0; i < 10 && i < n_ev; i++) if (ev[i] != i + 1) bad++;
    chk(bad == 0, {tag, " power event order"}, n_ev, 10);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready === 1'b1, "R10 reset req_ready", int'(req_ready), 1);
    chk(out_valid === 1'b0 && done === 1'b0, "R10 reset outputs idle", int'(out_valid), 0);
    chk(iso === 1'b1 && sw1 === 1'b0 && sw2 === 1'b0, "R3 reset power state", int'(iso), 1);
    chk(wm === 1'b0 && burst === 1'b0 && freq === 1'b0, "R6 reset fuse idle", int'(burst), 0);
  endtask

  task automatic t_normal();
    lat = 8'd3;
    run_req(16'h0040, 12, 1'b0);
    chk(done_err == 2'd0, "R7 normal status", int'(done_err), 0);
    chk(n_req == 3, "R6 request count", n_req, 3);
    chk(req_a[0] == 'h40 && req_a[1] == 'h44 && req_a[2] == 'h48, "R6 word addresses",
        req_a[2], 'h48);
    chk_bytes("R7 normal", 'h40, 12);
    chk_full_seq("R3 R4 normal");
    chk(sw2_up - sw1_up >= SETTLE, "R3 up settle gap", sw2_up - sw1_up, SETTLE);
    chk(sw1_dn - sw2_dn >= SETTLE, "R4 down settle gap", sw1_dn - sw2_dn, SETTLE);
    chk(done_cnt == 1, "R10 done width", done_cnt, 1);
    chk(rr_bad == 0, "R10 req_ready while busy", rr_bad, 0);
  endtask

  task automatic t_misalign();
    run_req(16'h0012, 4, 1'b0);
    chk(done_err == 2'd1, "R1 misaligned address status", int'(done_err), 1);
    chk(n_ev == 0 && n_req == 0 && n_byte == 0, "R1 no activity (addr)", n_ev + n_req + n_byte, 0);
    run_req(16'h0020, 6, 1'b0);
    chk(done_err == 2'd1, "R1 misaligned length status", int'(done_err), 1);
    chk(n_ev == 0 && n_req == 0 && n_byte == 0, "R1 no activity (len)", n_ev + n_req + n_byte, 0);
  endtask

  task automatic t_zero();
    run_req(16'h0080, 0, 1'b0);
    chk(done_err == 2'd0, "R2 zero length status", int'(done_err), 0);
    chk(n_ev == 0 && n_req == 0 && n_byte == 0, "R2 no activity", n_ev + n_req + n_byte, 0);
  endtask

  task automatic t_skip();
    int e[4] = '{1, 5, 9, 10};
    int bad;
    lat = 8'd1;
    run_req(16'h1230, 8, 1'b1);
    chk(done_err == 2'd0, "R5 skip status", int'(done_err), 0);
    bad = (n_ev != 4) ? 1 : 0;
    for (int i = 0; i < 4 && i < n_ev; i++) if (ev[i] != e[i]) bad++;
    chk(bad == 0, "R5 skip power events", n_ev, 4);
    chk_bytes("R5 skip", 'h1230, 8);
  endtask

  task automatic t_timeout();
    hang = 1'b1;
    run_req(16'h0100, 8, 1'b0);
    hang = 1'b0;
    chk(done_err == 2'd2, "R8 timeout status", int'(done_err), 2);
    chk(n_byte == 0, "R8 no bytes after timeout", n_byte, 0);
    chk(n_req == 1, "R8 single request", n_req, 1);
    chk_full_seq("R8 power down after timeout");
  endtask

  task automatic t_backpressure();
    lat = 8'd0;
    bp_en = 1'b1;
    run_req(16'h2000, 16, 1'b0);
    bp_en = 1'b0;
    chk(done_err == 2'd0, "R9 backpressure status", int'(done_err), 0);
    chk_bytes("R9 backpressure", 'h2000, 16);
    chk(stall_bad == 0, "R9 hold under stall", stall_bad, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_normal();
    t_misalign();
    t_zero();
    t_skip();
    t_timeout();
    t_backpressure();
    lat = 8'd7;
    run_req(16'h0004, 4, 1'b0);
    chk_bytes("R7 single word long latency", 'h0004, 4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule